// File: doc/BRIEF.md
# DRAM Clock-Enable Power-State Sequencer

This block sits between the command scheduler of a DDR3-class memory controller and the memory's clock-enable pin. The scheduler reports every command it issues and raises requests for power-down, self-refresh and wake-up. The sequencer then decides on which clock edge the clock-enable output may fall and on which edge it may rise again. It also tells the scheduler when normal commands may be issued, and when commands that need a locked DLL may be issued.

Power-down or self-refresh entry is held back until the delay owed to the most recent command has run out. That delay depends on the command kind, on the burst mode, and on the read latency, write latency and write-recovery settings. The output stays low for a minimum pulse, and stays high for a minimum pulse after each wake-up. Commands are blocked until the exit recovery time has passed. Every nanosecond limit is turned into a clock count at elaboration, rounding up from a clock-period parameter given in picoseconds.

Requests that cannot be served yet are held pending, not dropped. All pins are plain level or strobe controls: there is no data stream and no back-pressure, because the scheduler is expected to follow `cmd_allowed`. An overrun flag reports a power-down that lasts longer than nine refresh intervals.

Top module: `cke_power_seq`

## Requirements
- R1: After reset, `cke`, `cmd_allowed` and `dll_cmd_allowed` are 1 and `pd_overrun` is 0.
- R2: `cmd_type` codes are 0 activate, 1 precharge, 2 refresh, 3 mode-register set, 4 read (with or without auto-precharge), 5 write, 6 write with auto-precharge, and 7 any other command. A command sampled at edge k with entry pending lets `cke` fall no earlier than edge k+D. For codes 0, 1, 2 and 7, D = 1. For code 3, D = TMOD_CK.
- R3: For a read, D = RL_CK + 5, whatever the value of `cmd_chop`.
- R4: For a write, D = WL_CK + 4 + ceil(TWR_PS/CLK_PS). With `cmd_chop` = 1 (burst chop 4 fixed in the mode register), D = WL_CK + 2 + ceil(TWR_PS/CLK_PS).
- R5: For a write with auto-precharge, D = WL_CK + 4 + WR_CK + 1. With `cmd_chop` = 1, D = WL_CK + 2 + WR_CK + 1.
- R6: A later command with a shorter delay never shortens the wait still owed to an earlier command.
- R7: A `pd_req` or `sr_req` strobe is held until entry is legal, and entry then happens on the first legal edge. A command sampled on the same edge blocks entry on that edge.
- R8: Once `cke` falls, it stays low for at least tCKE clocks in power-down and at least SR_LOW clocks in self-refresh. tCKE = max(3, ceil(5 ns)). SR_LOW = max(tCKE+1, 2·max(5, ceil(10 ns))). An earlier `exit_req` is deferred, not dropped.
- R9: After `cke` rises, it stays high for at least tCKE clocks before the next entry.
- R10: `cmd_allowed` is 0 while `cke` is low. After `cke` rises at edge e, the first command may be sampled at edge e + tXP, where tXP = max(3, ceil(6 ns)). Sampled just after edge e, `cmd_allowed` therefore reads 0 for tXP−1 cycles.
- R11: `dll_cmd_allowed` reads 0 for tXPDLL−1 cycles after a self-refresh exit, or after a power-down exit with `dll_off` = 1. tXPDLL = max(10, ceil(24 ns)). Otherwise it follows `cmd_allowed`.
- R12: When both requests are pending, self-refresh is entered rather than power-down.
- R13: `exit_req` while `cke` is high has no effect. `pd_req` and `sr_req` while `cke` is low have no effect.
- R14: `pd_overrun` rises after 9·TREFI_CK cycles of continuous power-down. It stays 0 in self-refresh and clears when `cke` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is issued on this edge |
| cmd_type | input | 3 | Command code, see R2 |
| cmd_chop | input | 1 | Burst chop 4 is fixed in the mode register |
| pd_req | input | 1 | Request power-down entry (strobe) |
| sr_req | input | 1 | Request self-refresh entry (strobe) |
| exit_req | input | 1 | Request wake-up (strobe) |
| dll_off | input | 1 | Power-down is precharge power-down with the DLL off |
| cke | output | 1 | Clock-enable to the memory |
| cmd_allowed | output | 1 | A command may be sampled at the next edge |
| dll_cmd_allowed | output | 1 | A DLL-dependent command may be sampled at the next edge |
| pd_overrun | output | 1 | Power-down has lasted past its maximum |

## Verification
The assertions assume the scheduler obeys the block's own output: `cmd_valid` is raised only while `cmd_allowed` is 1, so no command is sampled while `cke` is low or during exit recovery. The bench never issues a command until it has seen `cmd_allowed` high. Between cases it waits for `dll_cmd_allowed` and for the high-pulse minimum. It drives every input only at falling edges, so each request and each command is sampled on a single known rising edge.

// File: rtl/cke_seq_pkg.sv
`timescale 1ns/1ps
package cke_seq_pkg;

  typedef enum logic [2:0] {
    CMD_ACT   = 3'd0,
    CMD_PRE   = 3'd1,
    CMD_REF   = 3'd2,
    CMD_MRS   = 3'd3,
    CMD_RD    = 3'd4,
    CMD_WR    = 3'd5,
    CMD_WRA   = 3'd6,
    CMD_OTHER = 3'd7
  } cmd_kind_e;

  typedef enum logic [1:0] {
    ST_UP = 2'd0,
    ST_PD = 2'd1,
    ST_SR = 2'd2
  } cke_state_e;

  // round a picosecond limit up to whole clocks
  function automatic int ps_to_clk(input int ps, input int clk_ps);
    return (ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cke_down_timer.sv
`timescale 1ns/1ps
module cke_down_timer #(
  parameter int W        = 4,
  parameter int KEEP_MAX = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt;
  logic [W-1:0] dec;
  logic [W-1:0] nxt;

  assign dec = (cnt != '0) ? cnt - 1'b1 : '0;

  generate
    if (KEEP_MAX != 0) begin : g_keep
      // a shorter load never cuts an outstanding wait
      assign nxt = (load_val > dec) ? load_val : dec;
    end else begin : g_plain
      assign nxt = load_val;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= nxt;
    else           cnt <= dec;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/cke_entry_gate.sv
`timescale 1ns/1ps
module cke_entry_gate
  import cke_seq_pkg::*;
#(
  parameter int RL_CK   = 11,
  parameter int WL_CK   = 8,
  parameter int WR_CK   = 12,
  parameter int TWR_CK  = 12,
  parameter int TMOD_CK = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_type,
  input  logic       cmd_chop,
  output logic       entry_ok
);

  localparam int D_RD    = RL_CK + 5;
  localparam int D_WR8   = WL_CK + 4 + TWR_CK;
  localparam int D_WR4   = WL_CK + 2 + TWR_CK;
  localparam int D_WRA8  = WL_CK + 4 + WR_CK + 1;
  localparam int D_WRA4  = WL_CK + 2 + WR_CK + 1;
  localparam int D_MRS   = imax(TMOD_CK, 1);
  localparam int D_MAX   = imax(imax(D_RD, D_MRS), imax(D_WR8, D_WRA8));
  localparam int W       = $clog2(D_MAX + 1);

  cmd_kind_e    kind;
  logic [W-1:0] need;

  assign kind = cmd_kind_e'(cmd_type);

  // remaining clocks owed, minus the issuing edge itself
  always_comb begin
    case (kind)
      CMD_MRS: need = W'(D_MRS - 1);
      CMD_RD:  need = W'(D_RD - 1);
      CMD_WR:  need = cmd_chop ? W'(D_WR4 - 1)  : W'(D_WR8 - 1);
      CMD_WRA: need = cmd_chop ? W'(D_WRA4 - 1) : W'(D_WRA8 - 1);
      default: need = '0;
    endcase
  end

  cke_down_timer #(.W(W), .KEEP_MAX(1)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cmd_valid),
    .load_val (need),
    .done     (entry_ok)
  );

  // R3
  rd_blocks_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && kind == CMD_RD) |=> !entry_ok);

endmodule

// File: rtl/cke_state_ctrl.sv
`timescale 1ns/1ps
module cke_state_ctrl
  import cke_seq_pkg::*;
#(
  parameter int CKE_MIN = 4,
  parameter int SR_LOW  = 16,
  parameter int TXP     = 5,
  parameter int TXPDLL  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_req,
  input  logic sr_req,
  input  logic exit_req,
  input  logic cmd_valid,
  input  logic dll_off,
  input  logic entry_ok,
  output logic cke,
  output logic in_pd,
  output logic cmd_allowed,
  output logic dll_cmd_allowed
);

  localparam int TW    = $clog2(imax(imax(SR_LOW, TXPDLL), imax(CKE_MIN, TXP)) + 1);
  localparam int NT    = 4;
  localparam int T_LOW = 0;
  localparam int T_HI  = 1;
  localparam int T_XP  = 2;
  localparam int T_DLL = 3;

  cke_state_e    st;
  logic          pd_pend, sr_pend, exit_pend;
  logic          sr_go, pd_go, exit_want;
  logic          enter, leave, slow;
  logic [NT-1:0] t_load;
  logic [NT-1:0] t_done;
  logic [TW-1:0] t_val [NT];

  assign sr_go     = sr_pend | sr_req;
  assign pd_go     = pd_pend | pd_req;
  assign exit_want = exit_pend | exit_req;
  assign enter     = (st == ST_UP) && (sr_go || pd_go) && entry_ok &&
                     t_done[T_HI] && !cmd_valid;
  assign leave     = (st != ST_UP) && exit_want && t_done[T_LOW];
  assign slow      = (st == ST_SR) || dll_off;

  always_comb begin
    t_load         = '0;
    t_load[T_LOW]  = enter;
    t_load[T_HI]   = leave;
    t_load[T_XP]   = leave;
    t_load[T_DLL]  = leave;
    t_val[T_LOW]   = sr_go ? TW'(SR_LOW - 1) : TW'(CKE_MIN - 1);
    t_val[T_HI]    = TW'(CKE_MIN - 1);
    t_val[T_XP]    = TW'(TXP - 1);
    t_val[T_DLL]   = slow ? TW'(TXPDLL - 1) : '0;
  end

  generate
    for (genvar i = 0; i < NT; i++) begin : g_tmr
      cke_down_timer #(.W(TW), .KEEP_MAX(0)) u_t (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load[i]),
        .load_val (t_val[i]),
        .done     (t_done[i])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_UP;
      pd_pend   <= 1'b0;
      sr_pend   <= 1'b0;
      exit_pend <= 1'b0;
    end else begin
      case (st)
        ST_UP: begin
          exit_pend <= 1'b0;
          if (enter) begin
            st      <= sr_go ? ST_SR : ST_PD;
            pd_pend <= 1'b0;
            sr_pend <= 1'b0;
          end else begin
            pd_pend <= pd_go;
            sr_pend <= sr_go;
          end
        end
        default: begin
          pd_pend <= 1'b0;
          sr_pend <= 1'b0;
          if (leave) begin
            st        <= ST_UP;
            exit_pend <= 1'b0;
          end else begin
            exit_pend <= exit_want;
          end
        end
      endcase
    end
  end

  assign cke             = (st == ST_UP);
  assign in_pd           = (st == ST_PD);
  assign cmd_allowed     = cke && t_done[T_XP];
  assign dll_cmd_allowed = cmd_allowed && t_done[T_DLL];

  // R8
  low_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> $past(t_done[T_LOW]));

  // R9
  high_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> $past(t_done[T_HI] && entry_ok));

  // R10
  exit_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> !cmd_allowed);

  // R11
  slow_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cke) && $past(st == ST_SR)) |-> !t_done[T_DLL]);

endmodule

// File: rtl/cke_idle_monitor.sv
`timescale 1ns/1ps
module cke_idle_monitor #(
  parameter int LIMIT = 56160
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_pd,
  output logic pd_overrun
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!in_pd)     cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign pd_overrun = in_pd && (cnt == LIM);

  // R14
  overrun_in_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_overrun) |-> $past(in_pd));

endmodule

// File: rtl/cke_power_seq.sv
`timescale 1ns/1ps
module cke_power_seq
  import cke_seq_pkg::*;
#(
  parameter int CLK_PS   = 1250,
  parameter int RL_CK    = 11,
  parameter int WL_CK    = 8,
  parameter int WR_CK    = 12,
  parameter int TWR_PS   = 15000,
  parameter int TMOD_CK  = 12,
  parameter int TREFI_CK = 6240
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_type,
  input  logic       cmd_chop,
  input  logic       pd_req,
  input  logic       sr_req,
  input  logic       exit_req,
  input  logic       dll_off,
  output logic       cke,
  output logic       cmd_allowed,
  output logic       dll_cmd_allowed,
  output logic       pd_overrun
);

  localparam int CKE_MIN  = imax(3, ps_to_clk(5000, CLK_PS));
  localparam int TXP      = imax(3, ps_to_clk(6000, CLK_PS));
  localparam int TXPDLL   = imax(10, ps_to_clk(24000, CLK_PS));
  localparam int TCKSR    = imax(5, ps_to_clk(10000, CLK_PS));
  localparam int SR_LOW   = imax(CKE_MIN + 1, 2 * TCKSR);
  localparam int TWR_CK   = ps_to_clk(TWR_PS, CLK_PS);
  localparam int PD_LIMIT = 9 * TREFI_CK;

  logic entry_ok;
  logic in_pd;

  cke_entry_gate #(
    .RL_CK   (RL_CK),
    .WL_CK   (WL_CK),
    .WR_CK   (WR_CK),
    .TWR_CK  (TWR_CK),
    .TMOD_CK (TMOD_CK)
  ) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_type  (cmd_type),
    .cmd_chop  (cmd_chop),
    .entry_ok  (entry_ok)
  );

  cke_state_ctrl #(
    .CKE_MIN (CKE_MIN),
    .SR_LOW  (SR_LOW),
    .TXP     (TXP),
    .TXPDLL  (TXPDLL)
  ) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .pd_req          (pd_req),
    .sr_req          (sr_req),
    .exit_req        (exit_req),
    .cmd_valid       (cmd_valid),
    .dll_off         (dll_off),
    .entry_ok        (entry_ok),
    .cke             (cke),
    .in_pd           (in_pd),
    .cmd_allowed     (cmd_allowed),
    .dll_cmd_allowed (dll_cmd_allowed)
  );

  cke_idle_monitor #(.LIMIT(PD_LIMIT)) u_mon (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_pd      (in_pd),
    .pd_overrun (pd_overrun)
  );

endmodule

// File: tb/cke_power_seq_test.sv
`timescale 1ns/1ps
module cke_power_seq_test;

  localparam int CLK_PS = 1250;
  localparam int RL     = 11;
  localparam int WL     = 8;
  localparam int WRM    = 12;
  localparam int TWR_PS = 15000;
  localparam int TMOD   = 12;
  localparam int TREFI  = 4;

  localparam int C5    = (5000 + CLK_PS - 1) / CLK_PS;
  localparam int C6    = (6000 + CLK_PS - 1) / CLK_PS;
  localparam int C10   = (10000 + CLK_PS - 1) / CLK_PS;
  localparam int C24   = (24000 + CLK_PS - 1) / CLK_PS;
  localparam int CWR   = (TWR_PS + CLK_PS - 1) / CLK_PS;
  localparam int E_CKE = (C5 > 3) ? C5 : 3;
  localparam int E_TXP = (C6 > 3) ? C6 : 3;
  localparam int E_DLL = (C24 > 10) ? C24 : 10;
  localparam int E_SRE = (C10 > 5) ? C10 : 5;
  localparam int E_SRL = ((E_CKE + 1) > 2 * E_SRE) ? (E_CKE + 1) : 2 * E_SRE;
  localparam int E_LIM = 9 * TREFI;

  localparam int NV = 11;
  localparam int VT [NV] = '{0, 1, 2, 3, 4, 4, 5, 5, 6, 6, 7};
  localparam int VC [NV] = '{0, 0, 0, 0, 0, 1, 0, 1, 0, 1, 0};
  localparam int VE [NV] = '{1, 1, 1, TMOD, RL + 5, RL + 5,
                             WL + 4 + CWR, WL + 2 + CWR,
                             WL + 4 + WRM + 1, WL + 2 + WRM + 1, 1};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_type = 3'd0;
  logic       cmd_chop = 1'b0;
  logic       pd_req = 1'b0;
  logic       sr_req = 1'b0;
  logic       exit_req = 1'b0;
  logic       dll_off = 1'b0;
  logic       cke, cmd_allowed, dll_cmd_allowed, pd_overrun;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  cke_power_seq #(
    .CLK_PS   (CLK_PS),
    .RL_CK    (RL),
    .WL_CK    (WL),
    .WR_CK    (WRM),
    .TWR_PS   (TWR_PS),
    .TMOD_CK  (TMOD),
    .TREFI_CK (TREFI)
  ) uut (
    .clk             (clk),
    .rst_n           (rst_n),
    .cmd_valid       (cmd_valid),
    .cmd_type        (cmd_type),
    .cmd_chop        (cmd_chop),
    .pd_req          (pd_req),
    .sr_req          (sr_req),
    .exit_req        (exit_req),
    .dll_off         (dll_off),
    .cke             (cke),
    .cmd_allowed     (cmd_allowed),
    .dll_cmd_allowed (dll_cmd_allowed),
    .pd_overrun      (pd_overrun)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_allowed();
    for (int g = 0; g < 100 && !cmd_allowed; g++) step();
  endtask

  // issue a command together with a power-down request, count high samples
  task automatic cmd_then_enter(input int t, input int ch, output int n);
    wait_allowed();
    cmd_valid = 1'b1; cmd_type = 3'(t); cmd_chop = ch[0]; pd_req = 1'b1;
    step();
    cmd_valid = 1'b0; pd_req = 1'b0;
    n = 0;
    while (cke && n < 200) begin n++; step(); end
  endtask

  // called at a sample with cke low: request exit, measure low and recovery
  task automatic exit_measure(output int low_n, output int xp_n, output int dll_n);
    exit_req = 1'b1;
    low_n = 0;
    while (!cke && low_n < 200) begin low_n++; step(); exit_req = 1'b0; end
    exit_req = 1'b0;
    xp_n = 0; dll_n = 0;
    while (!dll_cmd_allowed && dll_n < 200) begin
      if (!cmd_allowed) xp_n++;
      dll_n++;
      step();
    end
    repeat (E_CKE + 2) step();
  endtask

  task automatic pulse_enter(input logic pd, input logic sr);
    pd_req = pd; sr_req = sr;
    step();
    pd_req = 1'b0; sr_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int n, lo, xp, dl;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    check("R1 cke", int'(cke), 1);
    check("R1 cmd_allowed", int'(cmd_allowed), 1);
    check("R1 dll_cmd_allowed", int'(dll_cmd_allowed), 1);
    check("R1 pd_overrun", int'(pd_overrun), 0);

    // table: R2 R3 R4 R5 entry delays, R7 same-edge blocking, R8 R10 recovery
    for (int i = 0; i < NV; i++) begin
      cmd_then_enter(VT[i], VC[i], n);
      check($sformatf("R2-5 entry delay vec%0d", i), n, VE[i]);
      exit_measure(lo, xp, dl);
      check($sformatf("R8 pd low vec%0d", i), lo, E_CKE);
      check($sformatf("R10 xp vec%0d", i), xp, E_TXP - 1);
      check($sformatf("R11 fast dll vec%0d", i), dl, E_TXP - 1);
    end

    // R6: read then activate, read's wait still governs
    wait_allowed();
    cmd_valid = 1'b1; cmd_type = 3'd4; cmd_chop = 1'b0;
    step();
    cmd_type = 3'd0; pd_req = 1'b1;
    step();
    cmd_valid = 1'b0; pd_req = 1'b0;
    n = 0;
    while (cke && n < 200) begin n++; step(); end
    check("R6 longest wait kept", n, RL + 5 - 1);
    exit_measure(lo, xp, dl);

    // R9 R7: request during high pulse is held, minimum high time kept
    cmd_then_enter(0, 0, n);
    exit_req = 1'b1; step(); exit_req = 1'b0;
    while (!cke) step();
    n = 1;
    pd_req = 1'b1; step(); pd_req = 1'b0;
    while (cke && n < 200) begin n++; step(); end
    check("R9 min high pulse", n, E_CKE);
    exit_measure(lo, xp, dl);

    // R8 R10 R11: self-refresh low time and slow recovery
    pulse_enter(1'b0, 1'b1);
    check("R7 sr entry at once", int'(cke), 0);
    exit_measure(lo, xp, dl);
    check("R8 sr low", lo, E_SRL);
    check("R10 sr xp", xp, E_TXP - 1);
    check("R11 sr dll", dl, E_DLL - 1);

    // R11: power-down with DLL off
    dll_off = 1'b1;
    pulse_enter(1'b1, 1'b0);
    exit_measure(lo, xp, dl);
    check("R11 dll_off dll", dl, E_DLL - 1);
    check("R10 dll_off xp", xp, E_TXP - 1);
    dll_off = 1'b0;

    // R12: both requests, self-refresh wins
    pulse_enter(1'b1, 1'b1);
    exit_measure(lo, xp, dl);
    check("R12 sr priority low", lo, E_SRL);

    // R7: self-refresh request waits behind a write
    wait_allowed();
    cmd_valid = 1'b1; cmd_type = 3'd5; cmd_chop = 1'b0; sr_req = 1'b1;
    step();
    cmd_valid = 1'b0; sr_req = 1'b0;
    n = 0;
    while (cke && n < 200) begin n++; step(); end
    check("R7 sr pending delay", n, WL + 4 + CWR);
    exit_measure(lo, xp, dl);
    check("R7 sr pending low", lo, E_SRL);

    // R13: exit while high ignored
    exit_req = 1'b1; step(); exit_req = 1'b0;
    step();
    pulse_enter(1'b1, 1'b0);
    repeat (10) step();
    check("R13 exit while high ignored", int'(cke), 0);
    exit_measure(lo, xp, dl);

    // R13: entry requests while low ignored
    pulse_enter(1'b1, 1'b0);
    pd_req = 1'b1; sr_req = 1'b1; step(); pd_req = 1'b0; sr_req = 1'b0;
    exit_measure(lo, xp, dl);
    repeat (30) step();
    check("R13 req while low ignored", int'(cke), 1);

    // R14: overrun after limit in power-down
    pulse_enter(1'b1, 1'b0);
    n = 0;
    while (!pd_overrun && n < 500) begin n++; step(); end
    check("R14 overrun time", n, E_LIM);
    check("R14 still low", int'(cke), 0);
    exit_req = 1'b1; step(); exit_req = 1'b0;
    check("R14 cleared on exit", int'(pd_overrun), 0);
    repeat (E_DLL + 5) step();

    // R14: none in self-refresh
    pulse_enter(1'b0, 1'b1);
    repeat (E_LIM + 20) step();
    check("R14 no overrun in sr", int'(pd_overrun), 0);
    exit_measure(lo, xp, dl);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule